// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

The block collects up to eight edge-triggered interrupt requests and presents one interrupt line to a processor. Software reaches it through a byte-wide register bus with two addresses, a low port and a high port. The command is decoded from the port address and from bits 4 and 3 of the written byte. Software first writes an initialization sequence that sets the base vector and the end-of-interrupt style. After that, the high port holds the interrupt mask. Writes to the low port carry end-of-interrupt, priority and read-select commands.

A rising edge on a request input latches that request. The priority resolver compares the highest-priority unmasked request with the highest-priority level in service, and raises the interrupt line when the request wins. Priority is circular: the level named as lowest is served last, and the level after it is served first. On an acknowledge pulse, the chosen request moves into service and a vector number made of the base and the level comes out in the next cycle.

There is one controller and no cascade. The single-controller flag only decides whether a third initialization word is expected. The level-trigger flag is accepted, and the inputs stay edge-sensitive.

Top module: `pic_top`

## Requirements
- R1: After reset, int_out and vector_valid are low, the mask reads 0xFF (all inputs masked), the lowest-priority level is 7, and the base vector is 0.
- R2: A 0-to-1 transition on irq_in[n] sets request bit n in the clock edge where it is seen. A request input held high does not set its bit again after the bit has been cleared.
- R3: A low-port write with bit 4 set starts initialization. It clears the mask and the in-service register, sets the lowest level to 7, turns off special mask mode, auto-EOI, rotation in auto-EOI and poll, and selects the request register for low-port reads. The next high-port writes are taken in this order: word 2; word 3 only if bit 1 of word 1 is 0; word 4 only if bit 0 of word 1 is 1. Bit 3 of word 1 is ignored, so the inputs stay edge-triggered. Outside this sequence, a high-port write loads the mask and a high-port read returns it.
- R4: One cycle after an acknowledge pulse on inta, vector_valid is high for that one cycle and vector_out = (word2 & 0xF8) | level.
- R5: int_out is high when a request bit that is not masked ranks above every in-service bit. Ranking starts at (lowest+1) mod 8, so input 0 ranks highest by default. A mask bit of 1 blocks its input.
- R6: An acknowledge clears the winning request bit and sets its in-service bit. When bit 1 of word 4 was 1 (auto-EOI), the in-service bit is not set. Without word 4, auto-EOI is off.
- R7: An acknowledge while int_out is low returns vector base|7 and changes neither register.
- R8: Writing 0x20 to the low port clears the highest-ranked in-service bit. Writing 0x60|L clears in-service bit L.
- R9: Writing 0xA0 clears the highest-ranked in-service bit n and makes n the lowest level. Writing 0xE0|L clears bit L and makes L the lowest level. Writing 0xC0|L sets the lowest level to L without clearing any bit.
- R10: Writing 0x80 turns on rotation in auto-EOI, and writing 0x00 turns it off. While rotation and auto-EOI are both on, each acknowledged level becomes the lowest level.
- R11: A low-port write with bit 3 set and bit 4 clear is a read/mode command. Bits 1..0 = 10 select the request register for low-port reads, 11 select the in-service register, and other values keep the current selection. Bits 6..5 = 11 turn special mask mode on and 10 turn it off. In special mask mode, any unmasked request that is not in service raises int_out.
- R12: When bit 2 of that command is set, the next low-port read returns 0x80|level of the winning request and acknowledges it as in R6. If no request wins, the read returns 0x00. The read-select setting applies again after that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_rd | input | 1 | Register read strobe; side effects occur at the clock edge |
| bus_addr | input | 1 | 0 selects the low port, 1 the high port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port, combinational |
| irq_in | input | 8 | Edge-triggered request inputs |
| int_out | output | 1 | Interrupt line to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle |
| vector_out | output | 8 | Vector number of the last acknowledge |
| vector_valid | output | 1 | High in the cycle after an acknowledge |

## Verification
A wrong in-service bit or a wrong lowest-priority pointer stays hidden until the next request competes with it. It then shows as a wrong vector, one cycle after the acknowledge, or as int_out staying low or high in the cycle right after the request edge. A corrupted mask or request bit can be read back through the bus at once, in the same cycle it is addressed. The bench therefore reads the registers back between commands and runs long random sequences of masks, request edges and priority moves. Each vector is compared with a circular-priority pick that the bench computes itself.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_IN   = 8;
    localparam int LVL_W    = $clog2(NUM_IN);
    localparam int BASE_W   = 8 - LVL_W;

    typedef logic [NUM_IN-1:0] lvl_vec_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic [1:0] {
        INIT_IDLE,
        INIT_W2,
        INIT_W3,
        INIT_W4
    } init_state_e;

    typedef enum logic [2:0] {
        OP_CLR_RAEOI = 3'b000,
        OP_NS_EOI    = 3'b001,
        OP_NOP       = 3'b010,
        OP_SP_EOI    = 3'b011,
        OP_SET_RAEOI = 3'b100,
        OP_ROT_NS    = 3'b101,
        OP_SET_PRIO  = 3'b110,
        OP_ROT_SP    = 3'b111
    } op2_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_INIT1,
        CMD_OP2,
        CMD_OP3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        op2_e      op;
        lvl_t      lvl;
        logic      need_w4;
        logic      single;
        logic      rsel_en;
        logic      rsel_isr;
        logic      poll_req;
        logic      smm_en;
        logic      smm_set;
    } cmd_t;

    typedef struct packed {
        logic found;
        lvl_t lvl;
    } pick_t;

    // Scan from the lowest-ranked level up; the last hit is the highest-ranked one.
    function automatic pick_t pick_top(lvl_vec_t v, lvl_t lowest);
        pick_t p;
        lvl_t  idx;
        p = '0;
        for (int k = NUM_IN - 1; k >= 0; k--) begin
            idx = lowest + lvl_t'(k + 1);
            if (v[idx]) begin
                p.found = 1'b1;
                p.lvl   = idx;
            end
        end
        return p;
    endfunction

    // Rank 0 is the highest priority.
    function automatic lvl_t rank_of(lvl_t n, lvl_t lowest);
        return n - lowest - lvl_t'(1);
    endfunction

    function automatic lvl_vec_t onehot(lvl_t n);
        return lvl_vec_t'(1) << n;
    endfunction

endpackage

// File: rtl/pic_edge_irr.sv
module pic_edge_irr
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t irq_in,
    input  lvl_vec_t clr,
    output lvl_vec_t irr
);
    lvl_vec_t prev_q;
    lvl_vec_t irr_q;
    lvl_vec_t rise;

    always_comb rise = irq_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq_in;
            irr_q  <= (irr_q & ~clr) | rise;
        end
    end

    assign irr = irr_q;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  lvl_vec_t irr,
    input  lvl_vec_t isr,
    input  lvl_vec_t imr,
    input  lvl_t     lowest,
    input  logic     smm,
    output logic     int_req,
    output lvl_t     req_lvl,
    output pick_t    isr_top
);
    lvl_vec_t cand;
    pick_t    rp;
    pick_t    ip;

    always_comb begin
        cand = smm ? (irr & ~imr & ~isr) : (irr & ~imr);
        rp   = pick_top(cand, lowest);
        ip   = pick_top(isr, lowest);
        if (smm) begin
            int_req = rp.found;
        end else begin
            int_req = rp.found &&
                      (!ip.found || (rank_of(rp.lvl, lowest) < rank_of(ip.lvl, lowest)));
        end
        req_lvl = rp.lvl;
        isr_top = ip;
    end
endmodule

// File: rtl/pic_decode.sv
module pic_decode
    import pic_pkg::*;
(
    input  logic       wr,
    input  logic       addr,
    input  logic [7:0] wdata,
    output cmd_t       cmd
);
    always_comb begin
        if (!wr || addr)      cmd.kind = CMD_NONE;
        else if (wdata[4])    cmd.kind = CMD_INIT1;
        else if (wdata[3])    cmd.kind = CMD_OP3;
        else                  cmd.kind = CMD_OP2;
        cmd.op       = op2_e'(wdata[7:5]);
        cmd.lvl      = wdata[LVL_W-1:0];
        cmd.need_w4  = wdata[0];
        cmd.single   = wdata[1];
        cmd.rsel_en  = wdata[1];
        cmd.rsel_isr = wdata[0];
        cmd.poll_req = wdata[2];
        cmd.smm_en   = wdata[6];
        cmd.smm_set  = wdata[5];
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       cmd,
    input  logic       hi_wr,
    input  logic [7:0] hi_data,
    input  logic       lo_rd,
    input  logic       rd_hi,
    input  logic       inta,
    input  logic       int_req,
    input  lvl_t       req_lvl,
    input  pick_t      isr_top,
    input  lvl_vec_t   irr,
    output lvl_vec_t   imr,
    output lvl_vec_t   isr,
    output lvl_t       lowest,
    output logic       smm,
    output logic       aeoi,
    output lvl_vec_t   irr_clr,
    output logic [7:0] rdata,
    output logic [7:0] vector_out,
    output logic       vector_valid
);
    init_state_e      state_q;
    logic [BASE_W-1:0] base_q;
    logic             need_w4_q, single_q;
    logic             rot_aeoi_q, rd_isr_q, poll_q;
    lvl_vec_t         imr_q, isr_q;
    lvl_t             lowest_q;
    logic             smm_q, aeoi_q;
    logic [7:0]       vec_q;
    logic             vld_q;

    logic             ack;
    lvl_vec_t         ack_bit, isr_clr, isr_set;
    lvl_t             lowest_n;

    always_comb begin
        ack      = (inta && int_req) || (lo_rd && poll_q && int_req);
        ack_bit  = ack ? onehot(req_lvl) : '0;
        isr_set  = (ack && !aeoi_q) ? ack_bit : '0;
        isr_clr  = '0;
        lowest_n = lowest_q;
        if (ack && aeoi_q && rot_aeoi_q) lowest_n = req_lvl;
        if (cmd.kind == CMD_OP2) begin
            case (cmd.op)
                OP_NS_EOI: if (isr_top.found) isr_clr = onehot(isr_top.lvl);
                OP_SP_EOI: isr_clr = onehot(cmd.lvl);
                OP_ROT_NS: if (isr_top.found) begin
                    isr_clr  = onehot(isr_top.lvl);
                    lowest_n = isr_top.lvl;
                end
                OP_ROT_SP: begin
                    isr_clr  = onehot(cmd.lvl);
                    lowest_n = cmd.lvl;
                end
                OP_SET_PRIO: lowest_n = cmd.lvl;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= INIT_IDLE;
            base_q     <= '0;
            need_w4_q  <= 1'b0;
            single_q   <= 1'b1;
            rot_aeoi_q <= 1'b0;
            rd_isr_q   <= 1'b0;
            poll_q     <= 1'b0;
            imr_q      <= '1;
            isr_q      <= '0;
            lowest_q   <= lvl_t'(NUM_IN - 1);
            smm_q      <= 1'b0;
            aeoi_q     <= 1'b0;
            vec_q      <= '0;
            vld_q      <= 1'b0;
        end else begin
            vld_q    <= inta;
            if (inta) vec_q <= {base_q, int_req ? req_lvl : lvl_t'(NUM_IN - 1)};
            isr_q    <= (isr_q & ~isr_clr) | isr_set;
            lowest_q <= lowest_n;
            if (lo_rd && poll_q) poll_q <= 1'b0;

            case (cmd.kind)
                CMD_INIT1: begin
                    state_q    <= INIT_W2;
                    need_w4_q  <= cmd.need_w4;
                    single_q   <= cmd.single;
                    imr_q      <= '0;
                    isr_q      <= '0;
                    lowest_q   <= lvl_t'(NUM_IN - 1);
                    smm_q      <= 1'b0;
                    rd_isr_q   <= 1'b0;
                    poll_q     <= 1'b0;
                    aeoi_q     <= 1'b0;
                    rot_aeoi_q <= 1'b0;
                end
                CMD_OP3: begin
                    if (cmd.rsel_en)  rd_isr_q <= cmd.rsel_isr;
                    if (cmd.poll_req) poll_q   <= 1'b1;
                    if (cmd.smm_en)   smm_q    <= cmd.smm_set;
                end
                CMD_OP2: begin
                    if (cmd.op == OP_SET_RAEOI) rot_aeoi_q <= 1'b1;
                    if (cmd.op == OP_CLR_RAEOI) rot_aeoi_q <= 1'b0;
                end
                default: ;
            endcase

            if (hi_wr) begin
                case (state_q)
                    INIT_IDLE: imr_q <= hi_data;
                    INIT_W2: begin
                        base_q <= hi_data[7:LVL_W];
                        if (!single_q)      state_q <= INIT_W3;
                        else if (need_w4_q) state_q <= INIT_W4;
                        else                state_q <= INIT_IDLE;
                    end
                    INIT_W3: state_q <= need_w4_q ? INIT_W4 : INIT_IDLE;
                    INIT_W4: begin
                        aeoi_q  <= hi_data[1];
                        state_q <= INIT_IDLE;
                    end
                    default: state_q <= INIT_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        if (rd_hi)          rdata = imr_q;
        else if (poll_q)    rdata = int_req ? {1'b1, {(BASE_W-1){1'b0}}, req_lvl} : 8'h00;
        else if (rd_isr_q)  rdata = isr_q;
        else                rdata = irr;
    end

    assign imr          = imr_q;
    assign isr          = isr_q;
    assign lowest       = lowest_q;
    assign smm          = smm_q;
    assign aeoi         = aeoi_q;
    assign irr_clr      = ack_bit;
    assign vector_out   = vec_q;
    assign vector_valid = vld_q;
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] irq_in,
    output logic       int_out,
    input  logic       inta,
    output logic [7:0] vector_out,
    output logic       vector_valid
);
    cmd_t     cmd;
    lvl_vec_t irr, isr, imr, irr_clr;
    lvl_t     lowest, req_lvl;
    logic     smm, aeoi, int_req;
    pick_t    isr_top;

    pic_decode u_dec (
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    pic_edge_irr u_irr (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .clr    (irr_clr),
        .irr    (irr)
    );

    pic_resolver u_res (
        .irr     (irr),
        .isr     (isr),
        .imr     (imr),
        .lowest  (lowest),
        .smm     (smm),
        .int_req (int_req),
        .req_lvl (req_lvl),
        .isr_top (isr_top)
    );

    pic_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .hi_wr        (bus_wr && bus_addr),
        .hi_data      (bus_wdata),
        .lo_rd        (bus_rd && !bus_addr),
        .rd_hi        (bus_addr),
        .inta         (inta),
        .int_req      (int_req),
        .req_lvl      (req_lvl),
        .isr_top      (isr_top),
        .irr          (irr),
        .imr          (imr),
        .isr          (isr),
        .lowest       (lowest),
        .smm          (smm),
        .aeoi         (aeoi),
        .irr_clr      (irr_clr),
        .rdata        (bus_rdata),
        .vector_out   (vector_out),
        .vector_valid (vector_valid)
    );

    assign int_out = int_req;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] irq_in,
    input logic       inta,
    input logic       int_out,
    input logic [7:0] vector_out,
    input logic       vector_valid,
    input lvl_vec_t   irr,
    input lvl_vec_t   isr,
    input lvl_vec_t   imr,
    input lvl_t       req_lvl,
    input logic       aeoi
);
    for (genvar g = 0; g < NUM_IN; g++) begin : g_edge
        a_r2_rise_sets_irr: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_in[g]) |=> irr[g]);
    end

    a_r3_init_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (imr == '0 && isr == '0));

    a_r4_valid_follows_ack: assert property (@(posedge clk) disable iff (rst)
        inta |=> vector_valid);

    a_r4_no_valid_without_ack: assert property (@(posedge clk) disable iff (rst)
        !inta |=> !vector_valid);

    a_r5_masked_no_int: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~imr) == '0) |-> !int_out);

    a_r6_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (inta && int_out && !aeoi && !bus_wr) |=> isr[$past(req_lvl)]);

    a_r6_aeoi_skips_isr: assert property (@(posedge clk) disable iff (rst)
        (inta && int_out && aeoi && !bus_wr) |=> !isr[$past(req_lvl)]);

    a_r7_spurious_level: assert property (@(posedge clk) disable iff (rst)
        (inta && !int_out) |=> (vector_out[LVL_W-1:0] == lvl_t'(NUM_IN - 1)));
endmodule

bind pic_top pic_checker i_pic_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq_in       (irq_in),
    .inta         (inta),
    .int_out      (int_out),
    .vector_out   (vector_out),
    .vector_valid (vector_valid),
    .irr          (irr),
    .isr          (isr),
    .imr          (imr),
    .req_lvl      (req_lvl),
    .aeoi         (aeoi)
);

// File: tb/test_pic_top.sv
`timescale 1ns/1ps
module test_pic_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] irq_in;
    logic       int_out, inta;
    logic [7:0] vector_out;
    logic       vector_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pic_top i_pic_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .int_out(int_out),
        .inta(inta), .vector_out(vector_out), .vector_valid(vector_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic pulse(input logic [7:0] m);
        irq_in = irq_in | m;
        tick();
        irq_in = irq_in & ~m;
        tick();
    endtask

    task automatic ack_chk(input string tag, input logic [7:0] exp);
        inta = 1'b1;
        tick();
        inta = 1'b0;
        chk({tag, " valid"}, {7'b0, vector_valid}, 8'h01);
        chk(tag, vector_out, exp);
    endtask

    task automatic int_chk(input string tag, input logic exp);
        chk(tag, {7'b0, int_out}, {7'b0, exp});
    endtask

    // Circular pick: first set bit starting at (lowest+1) mod 8.
    function automatic int model_pick(input logic [7:0] v, input int low);
        for (int k = 1; k <= 8; k++) begin
            if (v[(low + k) % 8]) return (low + k) % 8;
        end
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_irr, m, r;
        int low, p;
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        irq_in = 0; inta = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        int_chk("R1 int_out after reset", 1'b0);
        chk("R1 vector_valid after reset", {7'b0, vector_valid}, 8'h00);
        rd_chk("R1 mask after reset", 1'b1, 8'hFF);

        // R3 full sequence with word 3 and word 4
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01);
        rd_chk("R3 mask cleared by init", 1'b1, 8'h00);
        wr(1, 8'h5A);
        rd_chk("R3 mask load/readback", 1'b1, 8'h5A);
        wr(1, 8'h00);

        // R2 edge capture, R4 vector, R6 in-service, R8 EOI
        irq_in[3] = 1'b1; tick();
        rd_chk("R2 request bit set by edge", 1'b0, 8'h08);
        int_chk("R5 int_out with request", 1'b1);
        ack_chk("R4 vector base|3", 8'h43);
        wr(0, 8'h0B);
        rd_chk("R6 in-service after ack", 1'b0, 8'h08);
        wr(0, 8'h20);
        rd_chk("R8 non-specific EOI clears", 1'b0, 8'h00);
        wr(0, 8'h0A);
        rd_chk("R2 held input does not set again", 1'b0, 8'h00);
        irq_in[3] = 1'b0; tick();

        // R5 nesting by priority, R8 specific EOI
        pulse(8'h24);
        int_chk("R5 int_out two requests", 1'b1);
        ack_chk("R5 highest first (2)", 8'h42);
        int_chk("R5 lower request blocked", 1'b0);
        pulse(8'h02);
        int_chk("R5 higher request preempts", 1'b1);
        ack_chk("R5 nested vector 1", 8'h41);
        wr(0, 8'h0B);
        wr(0, 8'h20);
        rd_chk("R8 NS EOI clears top bit 1", 1'b0, 8'h04);
        wr(0, 8'h62);
        rd_chk("R8 specific EOI clears 2", 1'b0, 8'h00);
        ack_chk("R5 remaining request 5", 8'h45);
        wr(0, 8'h20);
        wr(0, 8'h0A);

        // R5 masking
        wr(1, 8'h10);
        pulse(8'h10);
        int_chk("R5 masked request no int", 1'b0);
        rd_chk("R5 masked request still pending", 1'b0, 8'h10);
        wr(1, 8'h00);
        int_chk("R5 unmask raises int", 1'b1);
        ack_chk("R5 vector after unmask", 8'h44);
        wr(0, 8'h20);

        // R7 spurious acknowledge
        ack_chk("R7 spurious vector", 8'h47);
        rd_chk("R7 request unchanged", 1'b0, 8'h00);
        wr(0, 8'h0B);
        rd_chk("R7 in-service unchanged", 1'b0, 8'h00);

        // R9 rotation
        wr(0, 8'hC4);
        pulse(8'h48);
        ack_chk("R9 set priority lowest=4 picks 6", 8'h46);
        wr(0, 8'hA0);
        ack_chk("R9 rotate NS EOI then 3", 8'h43);
        wr(0, 8'hE3);
        rd_chk("R9 rotate specific cleared 3", 1'b0, 8'h00);
        pulse(8'h14);
        ack_chk("R9 lowest=3 picks 4", 8'h44);
        wr(0, 8'h20);
        ack_chk("R9 then 2", 8'h42);
        wr(0, 8'h20);
        wr(0, 8'hC7);

        // R6 auto-EOI and R10 rotation in auto-EOI
        wr(0, 8'h13); wr(1, 8'h80); wr(1, 8'h03); wr(1, 8'h00);
        pulse(8'h02);
        ack_chk("R6 auto-EOI vector", 8'h81);
        wr(0, 8'h0B);
        rd_chk("R6 auto-EOI leaves in-service clear", 1'b0, 8'h00);
        wr(0, 8'h80);
        pulse(8'h05);
        ack_chk("R10 first pick 0", 8'h80);
        ack_chk("R10 then 2", 8'h82);
        pulse(8'h0A);
        ack_chk("R10 lowest=2 picks 3", 8'h83);
        ack_chk("R10 then 1", 8'h81);
        wr(0, 8'h00);
        pulse(8'h21);
        ack_chk("R10 lowest=1 picks 5", 8'h85);
        pulse(8'h08);
        ack_chk("R10 rotation off picks 3", 8'h83);
        ack_chk("R10 then 0", 8'h80);

        // R3 short sequence, level flag ignored, no word 4 means no auto-EOI
        wr(0, 8'h1A); wr(1, 8'h20); wr(1, 8'h33);
        rd_chk("R3 short sequence mask", 1'b1, 8'h33);
        irq_in[2] = 1'b1; tick();
        ack_chk("R3 vector new base", 8'h22);
        rd_chk("R3 level flag ignored, held input", 1'b0, 8'h00);
        irq_in[2] = 1'b0; tick();
        wr(0, 8'h0B);
        rd_chk("R6 no word 4 sets in-service", 1'b0, 8'h04);
        wr(0, 8'h12); wr(1, 8'h20); wr(1, 8'h00);
        wr(0, 8'h0B);
        rd_chk("R3 init clears in-service", 1'b0, 8'h00);

        // R11 special mask mode
        pulse(8'h02);
        ack_chk("R11 first vector", 8'h21);
        pulse(8'h10);
        int_chk("R11 blocked without special mask", 1'b0);
        wr(0, 8'h68);
        int_chk("R11 special mask lets lower in", 1'b1);
        ack_chk("R11 vector in special mask", 8'h24);
        wr(0, 8'h48);
        int_chk("R11 special mask off", 1'b0);
        wr(0, 8'h20); wr(0, 8'h20);
        rd_chk("R11 selection kept, in-service empty", 1'b0, 8'h00);

        // R12 poll
        pulse(8'h20);
        wr(0, 8'h0C);
        rd_chk("R12 poll word", 1'b0, 8'h85);
        rd_chk("R12 poll acked into in-service", 1'b0, 8'h20);
        wr(0, 8'h20);
        wr(0, 8'h0C);
        rd_chk("R12 poll with nothing pending", 1'b0, 8'h00);

        // Random phase: R5 R9 R4 against a circular-priority model
        void'($urandom(32'h5EED_1234));
        wr(0, 8'h13); wr(1, 8'h60); wr(1, 8'h01); wr(1, 8'h00);
        exp_irr = 8'h00;
        for (int it = 0; it < 300; it++) begin
            low = $urandom % 8;
            m   = 8'($urandom);
            r   = 8'($urandom);
            wr(0, 8'hC0 | 8'(low));
            wr(1, m);
            pulse(r);
            exp_irr = exp_irr | r;
            int_chk("R5 random int_out", (exp_irr & ~m) != 8'h00);
            rd_chk("R2 random request register", 1'b0, exp_irr);
            while ((exp_irr & ~m) != 8'h00) begin
                p = model_pick(exp_irr & ~m, low);
                ack_chk("R9 random vector", 8'h60 | 8'(p));
                exp_irr[p] = 1'b0;
                wr(0, 8'h20);
            end
            int_chk("R5 random idle", 1'b0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule